// File: doc/BRIEF.md
# Oscillator Frequency Error Evaluator

This block measures how far a local oscillator drifts from a slower reference. A reference pulse (`syncPulse`) arrives once per reference period. Each pulse loads an error counter with the number of local cycles expected in one period. The counter then runs down to zero and, if no pulse has come by then, runs back up. When the next pulse arrives, the counter value is the size of the frequency error and the phase gives its sign. A pulse seen while counting down means the local clock is slow. A pulse seen while counting up means it is fast.

At each evaluated pulse the error is captured and sorted into bands against a programmable limit L. Below 3L is the in-tolerance band, below 128L is the warning band, and anything larger is uncorrectable. A 6-bit saturating trim word is stepped toward the target according to the band. Sticky flags record the outcome. Each flag has its own clear strobe, and a single interrupt line reports the flags whose enable is set.

If the up-count reaches 128L with no pulse, the counter stops and holds until the next pulse. That pulse only restarts measurement. The first pulse after reset is treated the same way.

Top module: `fee_top`

## Requirements
- R1: After reset, `trimVal` equals the parameter `TRIM_RESET` (32), and `errCapture`, `capDirUp`, every flag and `irq` are 0.
- R2: A pulse loads the counter with `reloadVal`. The counter then decrements once per cycle until it is zero. The next cycle sets it to 1, and it increments from then on. A pulse that arrives right after reset or after a missed pulse only restarts the counter: it does not change the capture, the flags or the trim.
- R3: On an evaluated pulse, `errCapture` takes the counter value and `capDirUp` takes the phase (0 = counting down, meaning the local clock is slow; 1 = counting up, meaning it is fast). Both hold until the next evaluated pulse.
- R4: An evaluated pulse with error e < 3L sets `flagOk`. If e is nonzero, the trim moves by 1: up when slow, down when fast.
- R5: An evaluated pulse with 3L <= e < 128L sets `flagWarn`. The trim moves by 2 in the same direction rule as R4.
- R6: `flagExpSync` is set in the cycle after the down-count is seen at zero.
- R7: A pulse during the down phase with e >= 128L sets `flagSyncErr`, and the trim is left unchanged.
- R8: When the up-count reaches 128L, `flagSyncMiss` is set, and the counter holds its value until the next pulse.
- R9: A trim step that would go above 63 or below 0 leaves the trim at 63 or 0 and sets `flagTrimOvf`.
- R10: `flagErr` is the OR of `flagSyncErr`, `flagSyncMiss` and `flagTrimOvf`. Clear bit 2 clears all three.
- R11: Flags are sticky. Clear bit 0 clears OK, bit 1 clears warning, bit 2 clears the error group and bit 3 clears expected-pulse. If a flag is set and cleared in the same cycle, the set wins.
- R12: `irq` is high exactly when at least one of these holds: OK and enable bit 0, warning and enable bit 1, error and enable bit 2, expected-pulse and enable bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| syncPulse | input | 1 | One-cycle reference pulse, already synchronised |
| reloadVal | input | 16 | Expected local cycles per reference period |
| errLimit | input | 8 | Error limit L |
| intEn | input | 4 | Interrupt enables: OK, warning, error, expected-pulse |
| clrVec | input | 4 | Clear strobes, with the same bit order as `intEn` |
| trimVal | output | 6 | Trim word |
| errCapture | output | 16 | Counter value at the last evaluated pulse |
| capDirUp | output | 1 | Phase at the last evaluated pulse (1 = fast) |
| flagOk | output | 1 | In-tolerance flag |
| flagWarn | output | 1 | Warning-band flag |
| flagErr | output | 1 | Combined error flag |
| flagExpSync | output | 1 | Expected-pulse flag |
| flagSyncErr | output | 1 | Uncorrectable slow error flag |
| flagSyncMiss | output | 1 | Missed-pulse flag |
| flagTrimOvf | output | 1 | Trim saturation flag |
| irq | output | 1 | Interrupt request |

## Verification
A counter that is off by even one count, or is in the wrong phase, does not show at the ports right away. It surfaces at the next evaluated pulse as a wrong `errCapture` or `capDirUp`, and possibly as a wrong band flag and trim step. A bad expected-pulse or miss decision shows up sooner, within one cycle of the moment the counter crosses zero or 128L. Wrong trim saturation or a wrong flag-clear priority changes `trimVal`, the flags or `irq` on the edge that follows. For this reason the bench compares every output against its own model on every clock, with periods chosen to land in each band and on both phases.

// File: rtl/fee_pkg.sv
package fee_pkg;
  typedef enum logic [1:0] {PH_WAIT = 2'd0, PH_DOWN = 2'd1, PH_UP = 2'd2} fee_phase_e;

  typedef struct packed {
    logic       load;      // load reload value
    logic       decr;      // count down
    logic       incr;      // count up
    logic       toUp;      // zero reached: turn around to 1
    logic       capture;   // evaluated pulse: latch counter and phase
    logic       dirNow;    // phase at capture (1 = up / fast)
    logic [1:0] trimStep;  // 0, 1 or 2 steps
    logic       trimRaise; // 1 = raise trim
  } fee_strobes_t;
endpackage

// File: rtl/fee_datapath.sv
module fee_datapath
  import fee_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TRIM_W     = 6,
  parameter int TRIM_RESET = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  fee_strobes_t       strb,
  input  logic [CNT_W-1:0]   reloadVal,
  output logic [CNT_W-1:0]   cntVal,
  output logic [CNT_W-1:0]   errCapture,
  output logic               capDirUp,
  output logic [TRIM_W-1:0]  trimVal,
  output logic               trimOvfEvt
);
  localparam logic [TRIM_W-1:0] TRIM_MAX  = '1;
  localparam logic [TRIM_W-1:0] TRIM_INIT = TRIM_W'(TRIM_RESET);

  logic [TRIM_W-1:0] stepExt;
  logic              stepping;

  assign stepExt    = TRIM_W'(strb.trimStep);
  assign stepping   = strb.capture && (stepExt != '0);
  assign trimOvfEvt = stepping &&
                      (strb.trimRaise ? (trimVal > (TRIM_MAX - stepExt)) : (trimVal < stepExt));

  // error counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntVal <= '0;
    else if (strb.load) cntVal <= reloadVal;
    else if (strb.toUp) cntVal <= CNT_W'(1);
    else if (strb.decr) cntVal <= cntVal - CNT_W'(1);
    else if (strb.incr) cntVal <= cntVal + CNT_W'(1);
  end

  // capture of the error and its sign
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCapture <= '0;
      capDirUp   <= 1'b0;
    end else if (strb.capture) begin
      errCapture <= cntVal;
      capDirUp   <= strb.dirNow;
    end
  end

  // saturating trim
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trimVal <= TRIM_INIT;
    else if (stepping) begin
      if (trimOvfEvt)          trimVal <= strb.trimRaise ? TRIM_MAX : '0;
      else if (strb.trimRaise) trimVal <= trimVal + stepExt;
      else                     trimVal <= trimVal - stepExt;
    end
  end
endmodule

// File: rtl/fee_control.sv
module fee_control
  import fee_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncPulse,
  input  logic [LIM_W-1:0] errLimit,
  input  logic [3:0]       intEn,
  input  logic [3:0]       clrVec,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             trimOvfEvt,
  output fee_strobes_t     strb,
  output logic             isWaiting,
  output logic             flagOk,
  output logic             flagWarn,
  output logic             flagErr,
  output logic             flagExpSync,
  output logic             flagSyncErr,
  output logic             flagSyncMiss,
  output logic             flagTrimOvf,
  output logic             irq
);
  localparam int CMP_W = ((CNT_W > LIM_W + 7) ? CNT_W : LIM_W + 7) + 2;

  fee_phase_e phase, phaseNext;
  logic [CMP_W-1:0] cntX, cntNext, lim3, lim128;
  logic okEv, warnEv, serrEv, expEv, missEv, evalNow, isSlow;

  assign cntX    = CMP_W'(cntVal);
  assign cntNext = cntX + CMP_W'(1);
  assign lim3    = CMP_W'(errLimit) * CMP_W'(3);
  assign lim128  = CMP_W'(errLimit) << 7;
  assign evalNow = syncPulse && (phase != PH_WAIT);
  assign isSlow  = (phase == PH_DOWN);
  assign isWaiting = (phase == PH_WAIT);

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    okEv = 1'b0; warnEv = 1'b0; serrEv = 1'b0; expEv = 1'b0; missEv = 1'b0;
    if (syncPulse) begin
      strb.load = 1'b1;
      phaseNext = PH_DOWN;
      if (evalNow) begin
        strb.capture   = 1'b1;
        strb.dirNow    = !isSlow;
        strb.trimRaise = isSlow;
        if (cntX < lim3) begin
          okEv          = 1'b1;
          strb.trimStep = (cntVal != '0) ? 2'd1 : 2'd0;
        end else if (cntX < lim128) begin
          warnEv        = 1'b1;
          strb.trimStep = 2'd2;
        end else begin
          serrEv        = isSlow;
        end
      end
    end else if (phase == PH_DOWN) begin
      if (cntVal == '0) begin
        strb.toUp = 1'b1;
        expEv     = 1'b1;
        phaseNext = PH_UP;
      end else begin
        strb.decr = 1'b1;
      end
    end else if (phase == PH_UP) begin
      strb.incr = 1'b1;
      if (cntNext >= lim128) begin
        missEv    = 1'b1;
        phaseNext = PH_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_WAIT;
    else       phase <= phaseNext;
  end

  // sticky flags: set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagOk <= 1'b0; flagWarn <= 1'b0; flagExpSync <= 1'b0;
      flagSyncErr <= 1'b0; flagSyncMiss <= 1'b0; flagTrimOvf <= 1'b0;
    end else begin
      flagOk       <= (flagOk       && !clrVec[0]) || okEv;
      flagWarn     <= (flagWarn     && !clrVec[1]) || warnEv;
      flagSyncErr  <= (flagSyncErr  && !clrVec[2]) || serrEv;
      flagSyncMiss <= (flagSyncMiss && !clrVec[2]) || missEv;
      flagTrimOvf  <= (flagTrimOvf  && !clrVec[2]) || trimOvfEvt;
      flagExpSync  <= (flagExpSync  && !clrVec[3]) || expEv;
    end
  end

  assign flagErr = flagSyncErr || flagSyncMiss || flagTrimOvf;
  assign irq     = |({flagExpSync, flagErr, flagWarn, flagOk} & intEn);
endmodule

// File: rtl/fee_top.sv
module fee_top
  import fee_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LIM_W      = 8,
  parameter int TRIM_W     = 6,
  parameter int TRIM_RESET = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncPulse,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic [LIM_W-1:0]  errLimit,
  input  logic [3:0]        intEn,
  input  logic [3:0]        clrVec,
  output logic [TRIM_W-1:0] trimVal,
  output logic [CNT_W-1:0]  errCapture,
  output logic              capDirUp,
  output logic              flagOk,
  output logic              flagWarn,
  output logic              flagErr,
  output logic              flagExpSync,
  output logic              flagSyncErr,
  output logic              flagSyncMiss,
  output logic              flagTrimOvf,
  output logic              irq
);
  fee_strobes_t     strb;
  logic [CNT_W-1:0] cntVal;
  logic             trimOvfEvt;
  logic             isWaiting;

  fee_control #(.CNT_W(CNT_W), .LIM_W(LIM_W)) ctrl (
    .clk(clk), .rstN(rstN), .syncPulse(syncPulse), .errLimit(errLimit),
    .intEn(intEn), .clrVec(clrVec), .cntVal(cntVal), .trimOvfEvt(trimOvfEvt),
    .strb(strb), .isWaiting(isWaiting), .flagOk(flagOk), .flagWarn(flagWarn),
    .flagErr(flagErr), .flagExpSync(flagExpSync), .flagSyncErr(flagSyncErr),
    .flagSyncMiss(flagSyncMiss), .flagTrimOvf(flagTrimOvf), .irq(irq)
  );

  fee_datapath #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .TRIM_RESET(TRIM_RESET)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal),
    .cntVal(cntVal), .errCapture(errCapture), .capDirUp(capDirUp),
    .trimVal(trimVal), .trimOvfEvt(trimOvfEvt)
  );
endmodule

// File: rtl/fee_checker.sv
module fee_checker #(
  parameter int CNT_W  = 16,
  parameter int TRIM_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              syncPulse,
  input logic [3:0]        intEn,
  input logic [3:0]        clrVec,
  input logic [TRIM_W-1:0] trimVal,
  input logic [CNT_W-1:0]  errCapture,
  input logic [CNT_W-1:0]  cntVal,
  input logic              isWaiting,
  input logic              flagOk,
  input logic              flagSyncErr,
  input logic              irq
);
  localparam logic [TRIM_W-1:0] ONE  = TRIM_W'(1);
  localparam logic [TRIM_W-1:0] TWO  = TRIM_W'(2);

  // R3: capture changes only after a pulse
  assert_capture_on_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (errCapture != $past(errCapture)) |-> $past(syncPulse));

  // R4 R5: trim moves only after a pulse, by one or two steps
  assert_trim_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trimVal != $past(trimVal)) |->
      ($past(syncPulse) &&
       ((TRIM_W'(trimVal - $past(trimVal)) == ONE) || (TRIM_W'(trimVal - $past(trimVal)) == TWO) ||
        (TRIM_W'($past(trimVal) - trimVal) == ONE) || (TRIM_W'($past(trimVal) - trimVal) == TWO))));

  // R7: an uncorrectable error leaves the trim alone
  assert_trim_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flagSyncErr) && !$past(flagSyncErr)) |-> (trimVal == $past(trimVal)));

  // R8: counter holds while waiting after a miss
  assert_miss_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (isWaiting && $past(isWaiting) && !$past(syncPulse)) |-> (cntVal == $past(cntVal)));

  // R11: a flag falls only on its own clear strobe
  assert_sticky_ok_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagOk) |-> $past(clrVec[0]));

  // R12: no interrupt while every enable is off
  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == 4'b0) |-> !irq);
endmodule

bind fee_top fee_checker #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) chk (
  .clk(clk), .rstN(rstN), .syncPulse(syncPulse), .intEn(intEn), .clrVec(clrVec),
  .trimVal(trimVal), .errCapture(errCapture), .cntVal(cntVal), .isWaiting(isWaiting),
  .flagOk(flagOk), .flagSyncErr(flagSyncErr), .irq(irq)
);

// File: tb/tb_fee_top.sv
module tb_fee_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncPulse = 1'b0;
  logic [15:0] reloadVal = 16'd100;
  logic [7:0]  errLimit = 8'd4;
  logic [3:0]  intEn = 4'b0;
  logic [3:0]  clrVec = 4'b0;
  logic [5:0]  trimVal;
  logic [15:0] errCapture;
  logic capDirUp, flagOk, flagWarn, flagErr, flagExpSync, flagSyncErr, flagSyncMiss, flagTrimOvf, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fee_top dut (
    .clk(clk), .rstN(rstN), .syncPulse(syncPulse), .reloadVal(reloadVal),
    .errLimit(errLimit), .intEn(intEn), .clrVec(clrVec), .trimVal(trimVal),
    .errCapture(errCapture), .capDirUp(capDirUp), .flagOk(flagOk), .flagWarn(flagWarn),
    .flagErr(flagErr), .flagExpSync(flagExpSync), .flagSyncErr(flagSyncErr),
    .flagSyncMiss(flagSyncMiss), .flagTrimOvf(flagTrimOvf), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int mCnt, mPhase, mTrim, mCap;   // phase: 0 waiting, 1 down, 2 up
  bit mDir, mOk, mWarn, mExp, mSerr, mMiss, mOvf;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPhase = 0; mTrim = 32; mCap = 0; mDir = 0;
      mOk = 0; mWarn = 0; mExp = 0; mSerr = 0; mMiss = 0; mOvf = 0;
    end else begin
      bit sOk, sWarn, sExp, sSerr, sMiss, sOvf;
      int lim3, lim128, stepN;
      sOk = 0; sWarn = 0; sExp = 0; sSerr = 0; sMiss = 0; sOvf = 0;
      lim3 = 3 * int'(errLimit);
      lim128 = 128 * int'(errLimit);
      if (syncPulse) begin
        if (mPhase != 0) begin
          bit slow;
          slow = (mPhase == 1);
          mCap = mCnt; mDir = !slow; stepN = 0;
          if (mCnt < lim3) begin sOk = 1; stepN = (mCnt != 0) ? 1 : 0; end
          else if (mCnt < lim128) begin sWarn = 1; stepN = 2; end
          else if (slow) sSerr = 1;
          if (stepN != 0) begin
            if (slow) begin
              if (mTrim + stepN > 63) begin mTrim = 63; sOvf = 1; end else mTrim += stepN;
            end else begin
              if (mTrim - stepN < 0) begin mTrim = 0; sOvf = 1; end else mTrim -= stepN;
            end
          end
        end
        mCnt = int'(reloadVal); mPhase = 1;
      end else if (mPhase == 1) begin
        if (mCnt == 0) begin mPhase = 2; mCnt = 1; sExp = 1; end
        else mCnt -= 1;
      end else if (mPhase == 2) begin
        mCnt += 1;
        if (mCnt >= lim128) begin sMiss = 1; mPhase = 0; end
      end
      mOk   = (mOk   && !clrVec[0]) || sOk;
      mWarn = (mWarn && !clrVec[1]) || sWarn;
      mSerr = (mSerr && !clrVec[2]) || sSerr;
      mMiss = (mMiss && !clrVec[2]) || sMiss;
      mOvf  = (mOvf  && !clrVec[2]) || sOvf;
      mExp  = (mExp  && !clrVec[3]) || sExp;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic cmpVal(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  // compare every output each cycle, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rstN && !done) begin
        bit mErr, mIrq;
        mErr = mSerr || mMiss || mOvf;
        mIrq = (mOk && intEn[0]) || (mWarn && intEn[1]) || (mErr && intEn[2]) || (mExp && intEn[3]);
        cmpVal("R4 R5 R9 trimVal", int'(trimVal), mTrim);
        cmpVal("R2 R3 errCapture", int'(errCapture), mCap);
        cmpVal("R3 capDirUp", int'(capDirUp), int'(mDir));
        cmpVal("R4 R11 flagOk", int'(flagOk), int'(mOk));
        cmpVal("R5 R11 flagWarn", int'(flagWarn), int'(mWarn));
        cmpVal("R6 flagExpSync", int'(flagExpSync), int'(mExp));
        cmpVal("R7 flagSyncErr", int'(flagSyncErr), int'(mSerr));
        cmpVal("R8 flagSyncMiss", int'(flagSyncMiss), int'(mMiss));
        cmpVal("R9 flagTrimOvf", int'(flagTrimOvf), int'(mOvf));
        cmpVal("R10 flagErr", int'(flagErr), int'(mErr));
        cmpVal("R12 irq", int'(irq), int'(mIrq));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk) syncPulse = 1'b1;
    @(negedge clk) syncPulse = 1'b0;
  endtask

  task automatic clear(input logic [3:0] v);
    @(negedge clk) clrVec = v;
    @(negedge clk) clrVec = 4'b0;
  endtask

  task automatic period(input int gap);
    pulse();
    idle(gap);
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset values
    cmpVal("R1 trimVal reset", int'(trimVal), 32);
    cmpVal("R1 errCapture reset", int'(errCapture), 0);
    cmpVal("R1 flags reset", int'({flagOk, flagWarn, flagErr, flagExpSync, flagSyncErr,
                                    flagSyncMiss, flagTrimOvf, irq, capDirUp}), 0);
    @(negedge clk) rstN = 1'b1;

    // R2: first pulse only restarts
    period(60);
    cmpVal("R2 first pulse no capture", int'(errCapture), 0);
    cmpVal("R2 first pulse no trim", int'(trimVal), 32);

    // R4: in-band, exact and slightly slow / fast; R6 expected-pulse on long periods
    idle(38);
    period(99);
    period(94);
    period(90);
    // R5: warning slow, then fast in both bands
    period(79);
    period(108);
    period(140);

    // R11 R12: enables and clears
    @(negedge clk) intEn = 4'b1111;
    idle(3);
    clear(4'b0001);
    idle(2);
    clear(4'b0010);
    @(negedge clk) intEn = 4'b0100;
    clear(4'b1000);
    idle(2);
    cmpVal("R11 cleared ok stays low", int'(flagOk), 0);

    // R7: far too slow
    @(negedge clk) begin errLimit = 8'd1; reloadVal = 16'd1000; end
    period(300);
    pulse();
    idle(2);
    cmpVal("R7 sync error flagged", int'(flagSyncErr), 1);
    clear(4'b0100);

    // R8: missed pulse, counter holds, then restart only
    @(negedge clk) reloadVal = 16'd10;
    period(300);
    cmpVal("R8 miss flagged", int'(flagSyncMiss), 1);
    period(9);
    period(11);
    clear(4'b0100);

    // R9: saturate upward then downward
    @(negedge clk) begin errLimit = 8'd4; reloadVal = 16'd100; intEn = 4'b0110; end
    for (int i = 0; i < 20; i++) period(79);
    pulse();
    idle(2);
    cmpVal("R9 trim at top", int'(trimVal), 63);
    cmpVal("R9 overflow flagged", int'(flagTrimOvf), 1);
    clear(4'b0100);
    for (int i = 0; i < 36; i++) period(140);
    pulse();
    idle(2);
    cmpVal("R9 trim at bottom", int'(trimVal), 0);

    // R11: set and clear in the same cycle, set wins
    period(79);
    @(negedge clk) begin syncPulse = 1'b1; clrVec = 4'b0010; end
    @(negedge clk) begin syncPulse = 1'b0; clrVec = 4'b0000; end
    idle(2);

    // R2 R6: zero reload, and zero limit
    @(negedge clk) reloadVal = 16'd0;
    period(5);
    @(negedge clk) errLimit = 8'd0;
    period(5);
    period(5);
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule